// File: doc/BRIEF.md
# Serial-In Latched LED Channel Controller

This block is the digital control core of an eight-channel constant-current LED sink. A serial bit stream is shifted into a channel register on the rising clock edge. A transparent latch stage presents that register to the channel outputs while its open input is high, and freezes it when the input drops. A blanking input turns every channel off without disturbing the latched pattern. A dim input is passed on as a half-current request flag for the analog stage. A supply-low input forces all channels off and clears the stored state.

The serial input is a valid/ready stream. A bit is taken on a rising edge only when `ser_valid` and `ser_ready` are both high. `ser_ready` drops while this block is in supply lockout, or while the next block in a chain refuses data through `cas_ready`. A refused bit must be held by the sender until it is accepted.

Two cascade outputs carry the last register stage to a following device. `cas_data` changes on the rising edge. `cas_data_late` is the same bit re-registered on the falling edge, so it lags by half a period. `cas_valid` marks the cycles in which the next device must shift.

Top module: `led_sink_ctrl`

## Requirements
- R1: A bit is shifted in on a rising edge only when ser_valid and ser_ready are both high. Register bit 0 takes ser_data and every other bit moves up by one. The first of eight bits lands on chan_on[7] and the last on chan_on[0]. Without a handshake the register holds.
- R2: While latch_open is 1, chan_on follows the register contents, including a change made by a shift edge, with no further pulse.
- R3: While latch_open is 0, chan_on keeps the pattern held when latch_open last fell, however many bits are shifted.
- R4: When blank is 1, every bit of chan_on is 0.
- R5: Raising and then lowering blank restores the same chan_on pattern as before.
- R6: cas_data equals the top register bit and changes only on the rising edge.
- R7: cas_data_late takes cas_data's value on the falling edge, so it lags cas_data by half a clock period.
- R8: dim_req equals dim: 0 requests full current and 1 requests half current.
- R9: While supply_low is 1, chan_on is 0 and ser_ready is 0. The register and the latch clear on the next rising edge, so channels stay off after the supply recovers.
- R10: cas_valid is 1 exactly when ser_valid and ser_ready are both 1, and ser_ready is 0 whenever cas_ready is 0.
- R11: After reset, chan_on, cas_data and cas_data_late are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data bit |
| ser_valid | input | 1 | Serial bit present |
| ser_ready | output | 1 | Serial bit can be taken |
| latch_open | input | 1 | 1: latch transparent, 0: latch holds |
| blank | input | 1 | 1: all channels off |
| dim | input | 1 | 1: half-current request |
| supply_low | input | 1 | Supply lockout |
| chan_on | output | 8 | Per-channel on request |
| dim_req | output | 1 | Half-current flag for the analog stage |
| cas_data | output | 1 | Cascade bit, rising-edge timed |
| cas_data_late | output | 1 | Cascade bit, falling-edge timed |
| cas_valid | output | 1 | Next device must shift this cycle |
| cas_ready | input | 1 | Next device can shift |

## Verification
Two pairs of functions can coincide. The first pair is a shift edge while the latch is open. The bench raises latch_open before shifting and expects chan_on to take the new register value after that same edge. The second pair is a downstream lockout while the upstream sender holds ser_valid high. The bench locks out only the second device of a two-device chain. It then expects the first device to drop ser_ready and cas_valid and to keep its transparent pattern unchanged.

// File: rtl/led_sink_pkg.sv
package led_sink_pkg;
  localparam int unsigned DEF_CHANNELS = 8;

  function automatic logic chan_gate(input logic latched, input logic off_req);
    return latched & ~off_req;
  endfunction
endpackage

// File: rtl/led_shift_stage.sv
module led_shift_stage #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         din,
  input  logic         clear,
  output logic [N-1:0] sr,
  output logic [N-1:0] sr_nxt,
  output logic         late_bit
);
  localparam int unsigned TOP = N - 1;

  always_comb begin
    if (clear)     sr_nxt = '0;
    else if (step) sr_nxt = {sr[TOP-1:0], din};
    else           sr_nxt = sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_nxt;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) late_bit <= 1'b0;
    else        late_bit <= sr[TOP];
  end

  // R1: without an accepted bit the register keeps its contents
  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(sr));

  // R1: an accepted bit enters at bit 0
  p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (sr[0] == $past(din)));

  // R7: the late copy has caught up by the next rising edge
  p_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
    late_bit == sr[TOP]);
endmodule

// File: rtl/led_latch_stage.sv
module led_latch_stage #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic         clear,
  input  logic [N-1:0] src,
  input  logic [N-1:0] src_nxt,
  output logic [N-1:0] view
);
  logic [N-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold <= '0;
    else if (clear)  hold <= '0;
    else if (open_i) hold <= src_nxt;
  end

  assign view = open_i ? src : hold;

  // R3: a closed latch keeps its value across edges
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_i && !clear && $past(!open_i && !clear)) |-> $stable(view));

  // R9: lockout leaves the latch empty
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (hold == '0));
endmodule

// File: rtl/led_output_gate.sv
module led_output_gate #(
  parameter int unsigned N = 8
) (
  input  logic         blank,
  input  logic         lockout,
  input  logic [N-1:0] latched,
  output logic [N-1:0] chan
);
  import led_sink_pkg::*;
  logic off_req;
  assign off_req = blank | lockout;

  for (genvar g = 0; g < N; g++) begin : g_chan
    assign chan[g] = chan_gate(latched[g], off_req);
  end
endmodule

// File: rtl/led_sink_ctrl.sv
module led_sink_ctrl #(
  parameter int unsigned CHANNELS = led_sink_pkg::DEF_CHANNELS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_data,
  input  logic                ser_valid,
  output logic                ser_ready,
  input  logic                latch_open,
  input  logic                blank,
  input  logic                dim,
  input  logic                supply_low,
  output logic [CHANNELS-1:0] chan_on,
  output logic                dim_req,
  output logic                cas_data,
  output logic                cas_data_late,
  output logic                cas_valid,
  input  logic                cas_ready
);
  localparam int unsigned TOP = CHANNELS - 1;

  logic                step;
  logic [CHANNELS-1:0] sr, sr_nxt, latched;

  assign ser_ready = ~supply_low & cas_ready;
  assign step      = ser_valid & ser_ready;
  assign cas_valid = step;
  assign dim_req   = dim;
  assign cas_data  = sr[TOP];

  led_shift_stage #(.N(CHANNELS)) u_shift (
    .clk(clk), .rst_n(rst_n), .step(step), .din(ser_data),
    .clear(supply_low), .sr(sr), .sr_nxt(sr_nxt), .late_bit(cas_data_late)
  );

  led_latch_stage #(.N(CHANNELS)) u_latch (
    .clk(clk), .rst_n(rst_n), .open_i(latch_open), .clear(supply_low),
    .src(sr), .src_nxt(sr_nxt), .view(latched)
  );

  led_output_gate #(.N(CHANNELS)) u_gate (
    .blank(blank), .lockout(supply_low), .latched(latched), .chan(chan_on)
  );

  // R9: lockout empties the channel register
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> (sr == '0));
endmodule

// File: tb/led_sink_ctrl_bench.sv
module led_sink_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0, ser_valid = 1'b0;
  logic latch_open = 1'b0, blank = 1'b0, dim = 1'b0;
  logic up_low = 1'b0, dn_low = 1'b0;
  logic up_ready, dn_ready, up_cv, dn_cv;
  logic [7:0] up_chan, dn_chan;
  logic up_dim, dn_dim, up_cd, up_cdl, dn_cd, dn_cdl;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  led_sink_ctrl u_led_sink_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_valid(ser_valid),
    .ser_ready(up_ready), .latch_open(latch_open), .blank(blank), .dim(dim),
    .supply_low(up_low), .chan_on(up_chan), .dim_req(up_dim),
    .cas_data(up_cd), .cas_data_late(up_cdl), .cas_valid(up_cv),
    .cas_ready(dn_ready)
  );

  led_sink_ctrl u_dn (
    .clk(clk), .rst_n(rst_n), .ser_data(up_cd), .ser_valid(up_cv),
    .ser_ready(dn_ready), .latch_open(latch_open), .blank(blank), .dim(dim),
    .supply_low(dn_low), .chan_on(dn_chan), .dim_req(dn_dim),
    .cas_data(dn_cd), .cas_data_late(dn_cdl), .cas_valid(dn_cv),
    .cas_ready(1'b1)
  );

  // {dn_byte, up_byte, blank, dim, exp_up, exp_dn}
  localparam int NV = 4;
  localparam logic [33:0] VEC [NV] = '{
    {8'hA5, 8'h3C, 1'b0, 1'b0, 8'h3C, 8'hA5},
    {8'hFF, 8'h00, 1'b0, 1'b1, 8'h00, 8'hFF},
    {8'h81, 8'h7E, 1'b1, 1'b0, 8'h00, 8'h00},
    {8'h01, 8'h80, 1'b0, 1'b0, 8'h80, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edge_drive();
    @(posedge clk); #1;
  endtask

  task automatic sample();
    @(negedge clk); #1;
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i]; ser_valid = 1'b1;
      edge_drive();
    end
    ser_valid = 1'b0;
  endtask

  task automatic clear_chain();
    up_low = 1'b1; dn_low = 1'b1;
    edge_drive();
    up_low = 1'b0; dn_low = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    sample();
    // R11 reset state
    check("R11 chan", up_chan, 8'h00);
    check("R11 cascade", {6'b0, up_cd, up_cdl}, 8'h00);
    check("R10 ready idle", {7'b0, up_ready}, 8'h01);

    // table walk: 16 bits through the chain, latch pulse, blank and dim
    for (int v = 0; v < NV; v++) begin
      edge_drive();
      shift_bits({VEC[v][33:26], VEC[v][25:18]}, 16);
      latch_open = 1'b1;
      edge_drive();
      latch_open = 1'b0;
      blank = VEC[v][17]; dim = VEC[v][16];
      sample();
      check("R1/R4 up chan", up_chan, VEC[v][15:8]);
      check("R1/R4 dn chan", dn_chan, VEC[v][7:0]);
      check("R8 dim flag", {7'b0, up_dim}, {7'b0, VEC[v][16]});
      blank = 1'b0; dim = 1'b0;
    end

    // R5 blank and restore the last pattern (80 / 01)
    blank = 1'b1; sample();
    check("R4 blanked", up_chan, 8'h00);
    blank = 1'b0; sample();
    check("R5 restored up", up_chan, 8'h80);
    check("R5 restored dn", dn_chan, 8'h01);

    // R9 lockout forces off and clears
    up_low = 1'b1; dn_low = 1'b1; sample();
    check("R9 off in lockout", up_chan, 8'h00);
    check("R9 ready low", {7'b0, up_ready}, 8'h00);
    edge_drive();
    up_low = 1'b0; dn_low = 1'b0;
    latch_open = 1'b1; sample();
    check("R9 cleared after recovery", up_chan, 8'h00);
    latch_open = 1'b0;

    // R6/R7 cascade timing: 1 followed by seven 0s reaches the top bit
    edge_drive();
    shift_bits(16'h0080, 8);
    check("R6 cas_data after rising edge", {7'b0, up_cd}, 8'h01);
    check("R7 late not yet updated", {7'b0, up_cdl}, 8'h00);
    sample();
    check("R7 late after falling edge", {7'b0, up_cdl}, 8'h01);

    // R2 transparent latch follows a shift edge
    clear_chain();
    latch_open = 1'b1;
    shift_bits(16'h0001, 1);
    sample();
    check("R2 transparent 1", up_chan, 8'h01);
    shift_bits(16'h0000, 1);
    sample();
    check("R2 transparent 2", up_chan, 8'h02);

    // R3 closed latch ignores shifts
    latch_open = 1'b0;
    shift_bits(16'h0005, 3);
    sample();
    check("R3 hold", up_chan, 8'h02);

    // R10 downstream lockout stalls the upstream device
    latch_open = 1'b1;
    sample();
    check("R10 pre-stall view", up_chan, 8'h15);
    dn_low = 1'b1; ser_valid = 1'b1; ser_data = 1'b1;
    sample();
    check("R10 ready dropped", {7'b0, up_ready}, 8'h00);
    check("R10 cas_valid dropped", {7'b0, up_cv}, 8'h00);
    edge_drive();
    sample();
    check("R1 stalled register", up_chan, 8'h15);
    dn_low = 1'b0; sample();
    check("R10 cas_valid with handshake", {7'b0, up_cv}, 8'h01);
    ser_valid = 1'b0; latch_open = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule